// File: doc/BRIEF.md
# Memory protection entry write controller

This block owns the stored configuration of a bank of physical memory protection entries: one 8-bit configuration byte and one address word per entry, plus a 3-bit security control register. Software-visible CSR writes arrive on a single write port. A packed configuration write carries several entry bytes at once. Address writes and security writes target one register each. The block applies the locking rules, keeps only writes that really change a stored value, and raises a one-cycle invalidate pulse toward translation caches when permissions may have moved.

For each entry it also decodes the address-match mode. It drives per-entry bound-update strobes, so that a neighbouring checker recomputes region bounds only for the entries that were touched. It keeps a count of the entries whose match mode is not off. A combinational read port returns any register.

Top module: `pmpw_ctrl`

## Requirements
- R1: After reset every configuration byte, address word and security bit reads as zero, the invalidate pulse is low and the active count is zero.
- R2: A configuration write (kind code 0) with register index r places byte lane i of the data (bits 8i+7:8i) into entry 4r+i, for XLEN/8 lanes, and reading that register returns the same packing.
- R3: A configuration byte whose bit 7 (lock) is set is never changed by a write, while the other lanes of the same write are still applied.
- R4: Lanes or address indices that map to an entry at or beyond the implemented count are dropped, cause no invalidate and read back as zero.
- R5: A configuration write raises the invalidate pulse and recomputes the active count only when at least one lane is unlocked and differs from the stored byte; rewriting identical values produces no pulse.
- R6: The match mode of each entry is bits 4:3 of its byte (0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 naturally aligned power of two); the active count is the number of entries whose mode is not 0.
- R7: An address write (kind code 1) to an entry whose own lock bit is set is ignored.
- R8: An address write to entry k is ignored when entry k+1 is locked with mode 1; a locked k+1 in any other mode does not block it.
- R9: An accepted address write that changes the value raises the invalidate pulse and the bound-update strobe of entry k, and also that of entry k+1 when entry k+1 uses mode 1; an unchanged value raises neither.
- R10: With extended protection enabled, a security write (kind code 2) cannot clear bit 0 (lockdown) or bit 1 (whitelist policy) once set; bit 2 (rule-lock bypass) follows the data; the pulse fires only when bit 0 or bit 1 changes.
- R11: With extended protection disabled, a security write forces bits 0, 1 and 2 to zero and raises no pulse.
- R12: The invalidate pulse and bound-update strobes are high for exactly the one cycle after the edge that accepted the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_prot_en | input | 1 | Extended protection enable, applied to security writes |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write target: 0 config, 1 address, 2 security |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | XLEN | Write data |
| rd_kind | input | 2 | Read target, same coding as wr_kind |
| rd_idx | input | IDX_W | Register index of the read |
| rd_data | output | XLEN | Read data, combinational |
| flush_o | output | 1 | One-cycle translation-cache invalidate pulse |
| bound_upd_o | output | NUM | Per-entry bound recompute strobe |
| match_mode_o | output | 2*NUM | Match mode of each entry, two bits per entry |
| lock_o | output | NUM | Lock bit of each entry |
| active_cnt_o | output | CNT_W | Number of entries with a non-off match mode |
| sec_o | output | 3 | Security register: bit 0 lockdown, bit 1 whitelist, bit 2 bypass |

## Verification
Two functions can coincide in one cycle. A packed configuration write can carry a locked lane and a modified lane together. The bench writes a byte into an already locked entry while changing its neighbour. It judges the case by the read-back value, where the locked byte must stay intact and the neighbour must be new, and by a single invalidate pulse. An address write whose next entry is top-of-range must strobe two bound-update bits and the pulse in the same cycle. The bench compares the exact strobe vector with the one expected when the neighbour uses a different mode.

// File: rtl/pmpw_pkg.sv
package pmpw_pkg;

    typedef enum logic [1:0] {
        KIND_CFG  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_SEC  = 2'd2,
        KIND_NONE = 2'd3
    } wkind_e;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_e;

    localparam int LOCK_POS      = 7;
    localparam int MODE_LO       = 3;
    localparam int SEC_W         = 3;
    localparam int SEC_LOCKDOWN  = 0;
    localparam int SEC_WHITELIST = 1;
    localparam int SEC_BYPASS    = 2;

endpackage

// File: rtl/pmpw_cfg_slot.sv
module pmpw_cfg_slot
    import pmpw_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IDX_W = 5,
    parameter int ENTRY = 0
) (
    input  logic             wr_cfg,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [7:0]       cur,
    output logic [7:0]       nxt,
    output logic             modified
);
    localparam int LANES = XLEN / 8;

    logic       hit;
    logic [7:0] sel;

    // find the lane of the packed write that lands on this entry
    always_comb begin
        hit = 1'b0;
        sel = 8'h00;
        for (int l = 0; l < LANES; l++) begin
            if (int'(wr_idx) * 4 + l == ENTRY) begin
                hit = 1'b1;
                sel = wr_data[l*8 +: 8];
            end
        end
    end

    assign modified = wr_cfg && hit && !cur[LOCK_POS] && (sel != cur);
    assign nxt      = modified ? sel : cur;

endmodule

// File: rtl/pmpw_sec_unit.sv
module pmpw_sec_unit
    import pmpw_pkg::*;
(
    input  logic             ext_en,
    input  logic             wr_sec,
    input  logic [SEC_W-1:0] data,
    input  logic [SEC_W-1:0] cur,
    output logic [SEC_W-1:0] nxt,
    output logic             policy_chg
);
    always_comb begin
        nxt        = cur;
        policy_chg = 1'b0;
        if (wr_sec) begin
            if (ext_en) begin
                nxt                = data;
                nxt[SEC_LOCKDOWN]  = data[SEC_LOCKDOWN]  | cur[SEC_LOCKDOWN];
                nxt[SEC_WHITELIST] = data[SEC_WHITELIST] | cur[SEC_WHITELIST];
                policy_chg = (nxt[SEC_LOCKDOWN]  != cur[SEC_LOCKDOWN]) ||
                             (nxt[SEC_WHITELIST] != cur[SEC_WHITELIST]);
            end else begin
                nxt = '0;
            end
        end
    end

endmodule

// File: rtl/pmpw_rdmux.sv
module pmpw_rdmux
    import pmpw_pkg::*;
#(
    parameter int NUM   = 16,
    parameter int XLEN  = 32,
    parameter int IDX_W = 5
) (
    input  logic [1:0]          rd_kind,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [NUM*8-1:0]    cfg_flat,
    input  logic [NUM*XLEN-1:0] addr_flat,
    input  logic [SEC_W-1:0]    sec,
    output logic [XLEN-1:0]     rd_data
);
    localparam int LANES = XLEN / 8;

    always_comb begin
        rd_data = '0;
        case (wkind_e'(rd_kind))
            KIND_CFG: begin
                for (int l = 0; l < LANES; l++) begin
                    for (int e = 0; e < NUM; e++) begin
                        if (int'(rd_idx) * 4 + l == e) begin
                            rd_data[l*8 +: 8] = cfg_flat[e*8 +: 8];
                        end
                    end
                end
            end
            KIND_ADDR: begin
                for (int e = 0; e < NUM; e++) begin
                    if (int'(rd_idx) == e) begin
                        rd_data = addr_flat[e*XLEN +: XLEN];
                    end
                end
            end
            KIND_SEC: rd_data[SEC_W-1:0] = sec;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pmpw_ctrl.sv
module pmpw_ctrl
    import pmpw_pkg::*;
#(
    parameter int NUM  = 16,
    parameter int XLEN = 32,
    localparam int IDX_W = $clog2(NUM) + 1,
    localparam int CNT_W = $clog2(NUM + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_prot_en,
    input  logic                wr_en,
    input  logic [1:0]          wr_kind,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [XLEN-1:0]     wr_data,
    input  logic [1:0]          rd_kind,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [XLEN-1:0]     rd_data,
    output logic                flush_o,
    output logic [NUM-1:0]      bound_upd_o,
    output logic [2*NUM-1:0]    match_mode_o,
    output logic [NUM-1:0]      lock_o,
    output logic [CNT_W-1:0]    active_cnt_o,
    output logic [SEC_W-1:0]    sec_o
);

    typedef struct packed {
        logic [NUM-1:0][7:0]      cfg;
        logic [NUM-1:0][XLEN-1:0] addr;
        logic [SEC_W-1:0]         sec;
        logic [CNT_W-1:0]         cnt;
        logic                     flush;
        logic [NUM-1:0]           bupd;
    } state_t;

    state_t st_d, st_q;

    logic wr_cfg, wr_addr, wr_sec;
    assign wr_cfg  = wr_en && (wkind_e'(wr_kind) == KIND_CFG);
    assign wr_addr = wr_en && (wkind_e'(wr_kind) == KIND_ADDR);
    assign wr_sec  = wr_en && (wkind_e'(wr_kind) == KIND_SEC);

    logic [NUM-1:0][7:0] cfg_nxt;
    logic [NUM-1:0]      cfg_mod;
    logic [NUM-1:0]      next_tor;
    logic [NUM-1:0]      next_tor_lock;
    logic [NUM-1:0]      addr_sel;

    for (genvar e = 0; e < NUM; e++) begin : g_entry
        pmpw_cfg_slot #(.XLEN(XLEN), .IDX_W(IDX_W), .ENTRY(e)) u_slot (
            .wr_cfg   (wr_cfg),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .cur      (st_q.cfg[e]),
            .nxt      (cfg_nxt[e]),
            .modified (cfg_mod[e])
        );

        assign addr_sel[e] = wr_addr && (int'(wr_idx) == e);

        if (e < NUM - 1) begin : g_nb
            assign next_tor[e] =
                match_e'(st_q.cfg[e+1][MODE_LO +: 2]) == MATCH_TOR;
            assign next_tor_lock[e] = next_tor[e] && st_q.cfg[e+1][LOCK_POS];
        end else begin : g_last
            assign next_tor[e]      = 1'b0;
            assign next_tor_lock[e] = 1'b0;
        end

        assign match_mode_o[2*e +: 2] = st_q.cfg[e][MODE_LO +: 2];
        assign lock_o[e]              = st_q.cfg[e][LOCK_POS];
    end

    logic [SEC_W-1:0] sec_nxt;
    logic             sec_chg;

    pmpw_sec_unit u_sec (
        .ext_en     (ext_prot_en),
        .wr_sec     (wr_sec),
        .data       (wr_data[SEC_W-1:0]),
        .cur        (st_q.sec),
        .nxt        (sec_nxt),
        .policy_chg (sec_chg)
    );

    logic [CNT_W-1:0] cnt_new;
    always_comb begin
        cnt_new = '0;
        for (int e = 0; e < NUM; e++) begin
            if (cfg_nxt[e][MODE_LO +: 2] != 2'b00) begin
                cnt_new = cnt_new + CNT_W'(1);
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        st_d.bupd  = '0;

        // packed configuration bytes
        st_d.cfg = cfg_nxt;
        if (|cfg_mod) begin
            st_d.flush = 1'b1;
            st_d.bupd  = cfg_mod;
            st_d.cnt   = cnt_new;
        end

        // address words
        for (int e = 0; e < NUM; e++) begin
            if (addr_sel[e] && !st_q.cfg[e][LOCK_POS] && !next_tor_lock[e]
                && (st_q.addr[e] != wr_data)) begin
                st_d.addr[e] = wr_data;
                st_d.flush   = 1'b1;
                st_d.bupd[e] = 1'b1;
                if (next_tor[e] && (e + 1 < NUM)) begin
                    st_d.bupd[(e + 1) % NUM] = 1'b1;
                end
            end
        end

        // security register
        st_d.sec = sec_nxt;
        if (sec_chg) begin
            st_d.flush = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pmpw_rdmux #(.NUM(NUM), .XLEN(XLEN), .IDX_W(IDX_W)) u_rd (
        .rd_kind   (rd_kind),
        .rd_idx    (rd_idx),
        .cfg_flat  (st_q.cfg),
        .addr_flat (st_q.addr),
        .sec       (st_q.sec),
        .rd_data   (rd_data)
    );

    assign flush_o      = st_q.flush;
    assign bound_upd_o  = st_q.bupd;
    assign active_cnt_o = st_q.cnt;
    assign sec_o        = st_q.sec;

endmodule

// File: rtl/pmpw_chk.sv
module pmpw_chk
    import pmpw_pkg::*;
#(
    parameter int NUM   = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_prot_en,
    input logic             wr_en,
    input logic [1:0]       wr_kind,
    input logic             flush_o,
    input logic [NUM-1:0]   bound_upd_o,
    input logic [2*NUM-1:0] match_mode_o,
    input logic [NUM-1:0]   lock_o,
    input logic [CNT_W-1:0] active_cnt_o,
    input logic [SEC_W-1:0] sec_o
);

    // R12
    flush_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(wr_en));

    // R9
    strobe_with_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|bound_upd_o) |-> flush_o);

    // R10
    lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_prot_en) && $past(sec_o[SEC_LOCKDOWN])) |-> sec_o[SEC_LOCKDOWN]);

    // R10
    whitelist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_prot_en) && $past(sec_o[SEC_WHITELIST])) |-> sec_o[SEC_WHITELIST]);

    // R11
    sec_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_kind == 2'd2) && !ext_prot_en) |-> (sec_o == '0 && !flush_o));

    // R6
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_cnt_o <= CNT_W'(NUM));

    for (genvar e = 0; e < NUM; e++) begin : g_lk
        // R3
        locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_o[e] |=> (lock_o[e] && $stable(match_mode_o[2*e +: 2])));
    end

endmodule

bind pmpw_ctrl pmpw_chk #(.NUM(NUM), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_prot_en  (ext_prot_en),
    .wr_en        (wr_en),
    .wr_kind      (wr_kind),
    .flush_o      (flush_o),
    .bound_upd_o  (bound_upd_o),
    .match_mode_o (match_mode_o),
    .lock_o       (lock_o),
    .active_cnt_o (active_cnt_o),
    .sec_o        (sec_o)
);

// File: tb/sim_pmpw_ctrl.sv
module sim_pmpw_ctrl;

    localparam int NUM   = 16;
    localparam int XLEN  = 32;
    localparam int IDX_W = $clog2(NUM) + 1;
    localparam int CNT_W = $clog2(NUM + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_prot_en = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_kind = 2'd3;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [XLEN-1:0]  wr_data = '0;
    logic [1:0]       rd_kind = 2'd0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [XLEN-1:0]  rd_data;
    logic             flush_o;
    logic [NUM-1:0]   bound_upd_o;
    logic [2*NUM-1:0] match_mode_o;
    logic [NUM-1:0]   lock_o;
    logic [CNT_W-1:0] active_cnt_o;
    logic [2:0]       sec_o;

    always #10 clk = ~clk;

    pmpw_ctrl #(.NUM(NUM), .XLEN(XLEN)) u0 (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_idx = IDX_W'(idx); wr_data = d;
        rd_kind = k; rd_idx = IDX_W'(idx);
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3;
        #1;
    endtask

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  idx;
        logic [31:0] data;
        logic        flush;
        logic [31:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'd0,  32'h18100800, 1'b1, 32'h18100800, 4'd2},  // R2 packing
        '{2'd0, 8'd0,  32'h18100800, 1'b0, 32'h18100800, 4'd5},  // R5 same value
        '{2'd1, 8'd0,  32'h00001000, 1'b1, 32'h00001000, 4'd9},  // R9 change
        '{2'd1, 8'd0,  32'h00001000, 1'b0, 32'h00001000, 4'd9},  // R9 no change
        '{2'd0, 8'd1,  32'h00000088, 1'b1, 32'h00000088, 4'd2},  // R2 lock e4 TOR
        '{2'd1, 8'd3,  32'h00000055, 1'b0, 32'h00000000, 4'd8},  // R8 blocked
        '{2'd1, 8'd4,  32'h00000077, 1'b0, 32'h00000000, 4'd7},  // R7 own lock
        '{2'd0, 8'd1,  32'h00001818, 1'b1, 32'h00001888, 4'd3},  // R3 mixed lanes
        '{2'd0, 8'd3,  32'h08080808, 1'b1, 32'h08080808, 4'd2},  // R2 top entries
        '{2'd0, 8'd4,  32'hFFFFFFFF, 1'b0, 32'h00000000, 4'd4},  // R4 beyond cfg
        '{2'd1, 8'd16, 32'h00000001, 1'b0, 32'h00000000, 4'd4},  // R4 beyond addr
        '{2'd2, 8'd0,  32'h00000003, 1'b1, 32'h00000003, 4'd10}, // R10 set
        '{2'd2, 8'd0,  32'h00000000, 1'b0, 32'h00000003, 4'd10}, // R10 sticky
        '{2'd2, 8'd0,  32'h00000004, 1'b0, 32'h00000007, 4'd10}  // R10 bypass
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd_kind = 2'd0; rd_idx = '0; #1;
        chk("R1 cfg0", rd_data, 32'h0);
        rd_kind = 2'd1; #1;
        chk("R1 addr0", rd_data, 32'h0);
        chk("R1 sec", {29'd0, sec_o}, 32'h0);
        chk("R1 flush", {31'd0, flush_o}, 32'h0);
        chk("R1 count", {27'd0, active_cnt_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].kind, int'(VEC[i].idx), VEC[i].data);
            chk($sformatf("R%0d row%0d flush", VEC[i].req, i), {31'd0, flush_o}, {31'd0, VEC[i].flush});
            chk($sformatf("R%0d row%0d read", VEC[i].req, i), rd_data, VEC[i].rd);
        end

        // R6 mode decode and active count
        chk("R6 count", {27'd0, active_cnt_o}, 32'd9);
        chk("R6 mode e2", {30'd0, match_mode_o[5:4]}, 32'd2);
        chk("R6 mode e4", {30'd0, match_mode_o[9:8]}, 32'd1);
        chk("R3 lock e4", {31'd0, lock_o[4]}, 32'd1);

        // R9 neighbour top-of-range strobes two entries
        wr(2'd1, 0, 32'h2000);
        chk("R9 strobe tor", {16'd0, bound_upd_o}, 32'h0003);
        chk("R9 flush", {31'd0, flush_o}, 32'd1);
        @(negedge clk); #1;
        chk("R12 flush drop", {31'd0, flush_o}, 32'd0);
        chk("R12 strobe drop", {16'd0, bound_upd_o}, 32'd0);

        wr(2'd1, 1, 32'h3000);
        chk("R9 strobe single", {16'd0, bound_upd_o}, 32'h0002);

        // R3 locked lane untouched, e7 locked NAPOT
        wr(2'd0, 1, 32'h98001818);
        chk("R3 read", rd_data, 32'h98001888);
        chk("R5 flush", {31'd0, flush_o}, 32'd1);
        chk("R5 strobe", {16'd0, bound_upd_o}, 32'h0080);
        chk("R6 count2", {27'd0, active_cnt_o}, 32'd10);

        // R8 locked neighbour in NAPOT does not block
        wr(2'd1, 6, 32'h66);
        chk("R8 read", rd_data, 32'h66);
        chk("R8 flush", {31'd0, flush_o}, 32'd1);

        wr(2'd1, 7, 32'h1);
        chk("R7 read", rd_data, 32'h0);

        // R11 disabled extended protection clears security bits
        ext_prot_en = 1'b0;
        wr(2'd2, 0, 32'h7);
        chk("R11 sec", {29'd0, sec_o}, 32'h0);
        chk("R11 flush", {31'd0, flush_o}, 32'h0);
        ext_prot_en = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule